// File: doc/BRIEF.md
# Two-Wire Control and Status Slave

This block is the host-side register port of a card interface controller. A host reaches it over a two-wire serial bus. It can write one 8-bit control byte or read one 8-bit status byte per transaction. The bus lines are oversampled by the system clock, resynchronized and filtered, and a small protocol engine then recognizes START and STOP, compares the device address, acknowledges and shifts the data.

Three strap inputs pick one of eight device addresses. The status byte combines live levels (card present, card data line high, session active) with sticky event flags (presence changed, supply fault, overload, no answer, early answer). The sticky flags clear when the host reads them. An active-low interrupt stays asserted while any sticky flag is set or a supply fault is present. The warm-reset request bit in the control byte is cleared by hardware when the card starts its answer or is declared mute.

Top module: `sc_host_port`

## Requirements
- R1: The slave acknowledges only a first byte equal to {4'b0100, addr_strap_i[2:0], rw}. Any other first byte gets no acknowledge, and the rest of that transaction is ignored until the next START.
- R2: A write (rw=0) acknowledges the data byte and loads it into ctrl_o.
- R3: A read (rw=1) returns the status byte MSB first, with bit0 card present, bit1 presence changed, bit2 card data line high, bit3 supply fault, bit4 overload, bit5 no answer, bit6 early answer, bit7 session active.
- R4: After reset, ctrl_o is 0x00, irq_n_o is high, sda_oe_o is low, and with the card absent, its data line high and no session, the status reads 0x04.
- R5: Bits 1, 3 and 4 are set by their events (bit1 on either edge of card_present_i, bit4 on overload_pulse_i, bit3 while supply_fault_i is high) and clear after they have been read.
- R6: Bits 5 and 6 are set by mute_pulse_i and early_pulse_i and clear on a read or on a rising edge of session_active_i.
- R7: irq_n_o is low while any sticky bit is set or supply_fault_i is high. It returns high after a status read unless the supply fault is still present.
- R8: A pulse on atr_start_pulse_i or mute_pulse_i clears ctrl_o bit 1 and leaves the other control bits unchanged.
- R9: A pulse on SCL or SDA shorter than FILT_LEN system clocks (60 ns at the default) has no effect on the transfer.
- R10: A START that arrives in the middle of a byte restarts address reception from the first bit.
- R11: An event that arrives after the address of a read has been matched is not cleared by that read and shows in the next read.
- R12: sda_oe_o is asserted only in acknowledge slots and for zero data bits of a read, and is never asserted while the slave is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| addr_strap_i | input | 3 | Low three bits of the device address |
| card_present_i | input | 1 | Live card presence level |
| card_io_high_i | input | 1 | Live level of the card data line |
| session_active_i | input | 1 | Live card session state |
| supply_fault_i | input | 1 | Supply fault level |
| overload_pulse_i | input | 1 | One-clock over-current or over-temperature event |
| mute_pulse_i | input | 1 | One-clock event: card did not answer in time |
| early_pulse_i | input | 1 | One-clock event: card answered too early |
| atr_start_pulse_i | input | 1 | One-clock event: card began its answer |
| ctrl_o | output | 8 | Control register contents |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The bench aims at the points where a register port like this one usually breaks. A slave that matched on the strap bits alone, or that did not go back to idle after a mismatch, would acknowledge the wrong address or take a later byte as data. A filter that was too short would count a 40 ns SCL spike as a clock edge and load a shifted control value. A START in mid-byte that did not reset the bit counter would misalign the address. The clear-on-read path is tested with an overload event injected in the middle of a read: a design that cleared from the live value would lose the event, one that never cleared would keep the interrupt low, and one that ignored a persisting supply fault would release the interrupt too early.

// File: rtl/sc_host_pkg.sv
// Shared constants and types of the two-wire control/status port.
// Assumes a byte-wide register interface with a 7-bit device address.
package sc_host_pkg;
    localparam int          BYTE_W      = 8;
    localparam logic [3:0]  DEV_ADDR_HI = 4'b0100;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_ADDR,
        BUS_ADDR_ACK,
        BUS_WR,
        BUS_WR_ACK,
        BUS_RD,
        BUS_RD_ACK,
        BUS_WAIT
    } bus_state_t;

    // Positions of the sticky event bits within the status byte.
    localparam logic [BYTE_W-1:0] EVT_MASK   = 8'b0111_1010;
    localparam logic [BYTE_W-1:0] ANSWER_MSK = 8'b0110_0000;
endpackage

// File: rtl/sc_line_filter.sv
// Resynchronizes one bus line and rejects pulses shorter than FILT_LEN clocks.
// Assumes SYNC_STAGES >= 2 and an idle-high line at reset.
module sc_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   filt_q;
    logic                   sync_s;

    assign sync_s = sync_q[SYNC_STAGES-1];
    assign line_o = filt_q;

    // Synchronizer chain into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    // Accept a new level only after FILT_LEN consecutive differing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else if (sync_s == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            filt_q <= sync_s;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    filt_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(sync_s) == filt_q));
endmodule

// File: rtl/sc_bus_engine.sv
// Protocol engine: START/STOP detection, address compare, acknowledge,
// one data byte in (write) or out (read). Works on filtered line levels.
// Assumes no clock stretching and one data byte per transaction.
module sc_bus_engine
    import sc_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic [2:0]        strap,
    input  logic [BYTE_W-1:0] status_snap,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data,
    output logic              snap_stb,
    output logic              done_stb
);
    bus_state_t        state_q;
    logic              scl_d, sda_d;
    logic [3:0]        bitcnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic              rw_q;
    logic              start_c, stop_c, scl_rise, scl_fall;

    assign start_c  = scl && scl_d && sda_d && !sda;
    assign stop_c   = scl && scl_d && !sda_d && sda;
    assign scl_rise = scl && !scl_d;
    assign scl_fall = !scl && scl_d;

    // Previous line levels for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    // Transaction state machine with shift register and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= BUS_IDLE;
            bitcnt_q <= '0;
            sh_q     <= '0;
            rw_q     <= 1'b0;
            sda_oe   <= 1'b0;
            wr_stb   <= 1'b0;
            wr_data  <= '0;
            snap_stb <= 1'b0;
            done_stb <= 1'b0;
        end else begin
            wr_stb   <= 1'b0;
            snap_stb <= 1'b0;
            done_stb <= 1'b0;
            if (start_c) begin
                state_q  <= BUS_ADDR;
                bitcnt_q <= '0;
                sda_oe   <= 1'b0;
            end else if (stop_c) begin
                state_q <= BUS_IDLE;
                sda_oe  <= 1'b0;
            end else begin
                case (state_q)
                    BUS_ADDR, BUS_WR: begin
                        if (scl_rise && bitcnt_q != 4'd8) begin
                            sh_q     <= {sh_q[BYTE_W-2:0], sda};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else if (scl_fall && bitcnt_q == 4'd8) begin
                            if (state_q == BUS_ADDR) begin
                                if (sh_q[7:1] == {DEV_ADDR_HI, strap}) begin
                                    state_q  <= BUS_ADDR_ACK;
                                    sda_oe   <= 1'b1;
                                    rw_q     <= sh_q[0];
                                    snap_stb <= sh_q[0];
                                end else begin
                                    state_q <= BUS_IDLE;
                                end
                            end else begin
                                wr_stb  <= 1'b1;
                                wr_data <= sh_q;
                                sda_oe  <= 1'b1;
                                state_q <= BUS_WR_ACK;
                            end
                        end
                    end
                    BUS_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt_q <= '0;
                            if (rw_q) begin
                                state_q <= BUS_RD;
                                sh_q    <= status_snap;
                                sda_oe  <= ~status_snap[BYTE_W-1];
                            end else begin
                                state_q <= BUS_WR;
                                sda_oe  <= 1'b0;
                            end
                        end
                    end
                    BUS_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            state_q <= BUS_WAIT;
                        end
                    end
                    BUS_RD: begin
                        if (scl_fall) begin
                            if (bitcnt_q == 4'd7) begin
                                sda_oe   <= 1'b0;
                                done_stb <= 1'b1;
                                state_q  <= BUS_RD_ACK;
                            end else begin
                                bitcnt_q <= bitcnt_q + 1'b1;
                                sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
                                sda_oe   <= ~sh_q[BYTE_W-2];
                            end
                        end
                    end
                    BUS_RD_ACK: begin
                        if (scl_rise) state_q <= BUS_WAIT;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R12
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_IDLE) |-> !sda_oe);
    // R10
    restart_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (state_q == BUS_ADDR && bitcnt_q == 4'd0));
    // R2
    write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (state_q == BUS_WR_ACK && sda_oe));
endmodule

// File: rtl/sc_status_bank.sv
// Control register, sticky event flags with clear-on-read, and interrupt.
// Assumes the status inputs are synchronous to clk and pulses last one clock.
module sc_status_bank
    import sc_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_present,
    input  logic              data_high,
    input  logic              session_active,
    input  logic              supply_fault,
    input  logic              overload_pulse,
    input  logic              mute_pulse,
    input  logic              early_pulse,
    input  logic              atr_pulse,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              snap_stb,
    input  logic              done_stb,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic [BYTE_W-1:0] status_snap,
    output logic              irq_n
);
    logic              pres_d, act_d;
    logic [BYTE_W-1:0] sticky_q, sticky_next, set_v, clr_v, live_v, status_word;
    logic [BYTE_W-1:0] ctrl_next;

    assign live_v      = {session_active, 4'b0000, data_high, 1'b0, card_present};
    assign status_word = (sticky_q & EVT_MASK) | live_v;
    assign set_v       = {1'b0, early_pulse, mute_pulse, overload_pulse,
                          supply_fault, 1'b0, card_present ^ pres_d, 1'b0};
    assign clr_v       = (done_stb ? (status_snap & EVT_MASK) : '0)
                       | ((session_active && !act_d) ? ANSWER_MSK : '0);
    assign sticky_next = ((sticky_q & ~clr_v) | set_v) & EVT_MASK;

    // Next control value: host write, then hardware clear of the warm-reset bit.
    always_comb begin
        ctrl_next = wr_stb ? wr_data : ctrl_q;
        if (atr_pulse || mute_pulse) ctrl_next[1] = 1'b0;
    end

    // Edge history of the live inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_d <= 1'b0;
            act_d  <= 1'b0;
        end else begin
            pres_d <= card_present;
            act_d  <= session_active;
        end
    end

    // Sticky flags, control register and registered interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
            ctrl_q   <= '0;
            irq_n    <= 1'b1;
        end else begin
            sticky_q <= sticky_next;
            ctrl_q   <= ctrl_next;
            irq_n    <= ~((|sticky_next) | supply_fault);
        end
    end

    // Status value frozen when a read address is matched.
    always_ff @(posedge clk) begin
        if (!rst_n)        status_snap <= '0;
        else if (snap_stb) status_snap <= status_word;
    end

    // R8
    warm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (atr_pulse || mute_pulse) |=> !ctrl_q[1]);
    // R7
    fault_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_fault |=> !irq_n);
    // R5
    prot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_stb && status_snap[4] && !overload_pulse) |=> !status_word[4]);
    // R11
    event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overload_pulse |=> status_word[4]);
    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !atr_pulse && !mute_pulse) |=> (ctrl_q == $past(wr_data)));
endmodule

// File: rtl/sc_host_port.sv
// Top of the two-wire control/status port: line filters, protocol engine,
// register bank. Assumes an open-drain data pad driven through sda_oe_o.
module sc_host_port #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] addr_strap_i,
    input  logic       card_present_i,
    input  logic       card_io_high_i,
    input  logic       session_active_i,
    input  logic       supply_fault_i,
    input  logic       overload_pulse_i,
    input  logic       mute_pulse_i,
    input  logic       early_pulse_i,
    input  logic       atr_start_pulse_i,
    output logic [7:0] ctrl_o,
    output logic       irq_n_o
);
    logic [1:0] raw_w, clean_w;
    logic       wr_stb, snap_stb, done_stb;
    logic [7:0] wr_data, status_snap;

    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        sc_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_w[g]),
            .line_o(clean_w[g])
        );
    end

    sc_bus_engine u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl        (clean_w[0]),
        .sda        (clean_w[1]),
        .strap      (addr_strap_i),
        .status_snap(status_snap),
        .sda_oe     (sda_oe_o),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .snap_stb   (snap_stb),
        .done_stb   (done_stb)
    );

    sc_status_bank u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .card_present  (card_present_i),
        .data_high     (card_io_high_i),
        .session_active(session_active_i),
        .supply_fault  (supply_fault_i),
        .overload_pulse(overload_pulse_i),
        .mute_pulse    (mute_pulse_i),
        .early_pulse   (early_pulse_i),
        .atr_pulse     (atr_start_pulse_i),
        .wr_stb        (wr_stb),
        .wr_data       (wr_data),
        .snap_stb      (snap_stb),
        .done_stb      (done_stb),
        .ctrl_q        (ctrl_o),
        .status_snap   (status_snap),
        .irq_n         (irq_n_o)
    );
endmodule

// File: tb/sc_host_port_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module sc_host_port_bench;
    localparam int Q = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [2:0] strap = 3'b101;
    logic       card_present = 1'b0, card_io_high = 1'b1, session_active = 1'b0;
    logic       supply_fault = 1'b0, overload = 1'b0, mute = 1'b0, early = 1'b0, atr = 1'b0;
    logic [7:0] ctrl;
    logic       irq_n;
    int         n_chk = 0, n_fail = 0;
    bit         finished = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    sc_host_port u_sc_host_port (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .addr_strap_i(strap), .card_present_i(card_present), .card_io_high_i(card_io_high),
        .session_active_i(session_active), .supply_fault_i(supply_fault),
        .overload_pulse_i(overload), .mute_pulse_i(mute), .early_pulse_i(early),
        .atr_start_pulse_i(atr), .ctrl_o(ctrl), .irq_n_o(irq_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        seen = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_wbyte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
        bus_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic bus_rbyte(input logic nack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            d[i] = s;
        end
        bus_bit(nack, s);
    endtask

    task automatic write_ctrl(input logic [7:0] abyte, input logic [7:0] d,
                              output logic ack_a, output logic ack_d);
        bus_start();
        bus_wbyte(abyte, ack_a);
        if (ack_a) bus_wbyte(d, ack_d);
        else ack_d = 1'b0;
        bus_stop();
        tick(4);
    endtask

    task automatic read_status(output logic [7:0] d);
        logic a;
        bus_start();
        bus_wbyte({4'b0100, strap, 1'b1}, a);
        bus_rbyte(1'b1, d);
        bus_stop();
        tick(4);
        check("R1 read address acknowledged", {7'd0, a}, 8'h01);
    endtask

    task automatic t_reset();
        logic [7:0] st;
        check("R4 ctrl after reset", ctrl, 8'h00);
        check("R4 irq_n after reset", {7'd0, irq_n}, 8'h01);
        check("R12 sda_oe idle after reset", {7'd0, sda_oe}, 8'h00);
        read_status(st);
        check("R4 R3 status after reset", st, 8'h04);
    endtask

    task automatic t_write();
        logic aa, ad;
        write_ctrl({4'b0100, strap, 1'b0}, 8'hA5, aa, ad);
        check("R2 address ack", {7'd0, aa}, 8'h01);
        check("R2 data ack", {7'd0, ad}, 8'h01);
        check("R2 ctrl loaded A5", ctrl, 8'hA5);
        write_ctrl({4'b0100, strap, 1'b0}, 8'h3C, aa, ad);
        check("R2 ctrl loaded 3C", ctrl, 8'h3C);
        check("R12 sda_oe released after write", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic t_wrong_addr();
        logic aa, ad;
        write_ctrl(8'h4C, 8'hFF, aa, ad);
        check("R1 other strap not acked", {7'd0, aa}, 8'h00);
        check("R1 ctrl unchanged after mismatch", ctrl, 8'h3C);
        write_ctrl(8'h5A, 8'hFF, aa, ad);
        check("R1 wrong prefix not acked", {7'd0, aa}, 8'h00);
        check("R1 ctrl unchanged after bad prefix", ctrl, 8'h3C);
        strap = 3'b000; tick(4);
        write_ctrl(8'h40, 8'h11, aa, ad);
        check("R1 strap 000 acked", {7'd0, aa}, 8'h01);
        check("R1 strap 000 write", ctrl, 8'h11);
        strap = 3'b101; tick(4);
    endtask

    task automatic t_sticky();
        logic [7:0] st;
        overload = 1'b1; tick(1); overload = 1'b0; tick(2);
        check("R7 irq low on overload", {7'd0, irq_n}, 8'h00);
        read_status(st);
        check("R5 overload seen", st, 8'h14);
        check("R7 irq released after read", {7'd0, irq_n}, 8'h01);
        read_status(st);
        check("R5 overload cleared", st, 8'h04);
        card_present = 1'b1; tick(3);
        read_status(st);
        check("R5 presence rise flagged", st, 8'h07);
        read_status(st);
        check("R5 presence change cleared", st, 8'h05);
        card_present = 1'b0; tick(3);
        read_status(st);
        check("R5 presence fall flagged", st, 8'h06);
        read_status(st);
        check("R5 presence fall cleared", st, 8'h04);
    endtask

    task automatic t_answer_bits();
        logic [7:0] st;
        mute = 1'b1; tick(1); mute = 1'b0; tick(2);
        read_status(st);
        check("R6 mute flagged", st, 8'h24);
        read_status(st);
        check("R6 mute cleared by read", st, 8'h04);
        early = 1'b1; tick(1); early = 1'b0;
        mute = 1'b1; tick(1); mute = 1'b0; tick(2);
        check("R7 irq low on answer events", {7'd0, irq_n}, 8'h00);
        session_active = 1'b1; tick(3);
        check("R6 irq high after session start", {7'd0, irq_n}, 8'h01);
        read_status(st);
        check("R6 R3 answer bits cleared by session", st, 8'h84);
        session_active = 1'b0; tick(3);
    endtask

    task automatic t_supply();
        logic [7:0] st;
        supply_fault = 1'b1; tick(3);
        check("R7 irq low on supply fault", {7'd0, irq_n}, 8'h00);
        read_status(st);
        check("R5 supply fault flagged", st, 8'h0C);
        check("R7 irq held by live fault", {7'd0, irq_n}, 8'h00);
        supply_fault = 1'b0; tick(3);
        check("R7 irq held by sticky fault", {7'd0, irq_n}, 8'h00);
        read_status(st);
        check("R5 sticky fault still set", st, 8'h0C);
        check("R7 irq released", {7'd0, irq_n}, 8'h01);
        read_status(st);
        check("R5 supply fault cleared", st, 8'h04);
    endtask

    task automatic t_warm();
        logic aa, ad;
        write_ctrl({4'b0100, strap, 1'b0}, 8'h03, aa, ad);
        check("R8 warm request set", ctrl, 8'h03);
        atr = 1'b1; tick(1); atr = 1'b0; tick(2);
        check("R8 cleared by answer start", ctrl, 8'h01);
        write_ctrl({4'b0100, strap, 1'b0}, 8'h83, aa, ad);
        mute = 1'b1; tick(1); mute = 1'b0; tick(2);
        check("R8 cleared by mute", ctrl, 8'h81);
        begin
            logic [7:0] st;
            read_status(st);
        end
    endtask

    task automatic t_glitch();
        logic a, s;
        logic [7:0] d = 8'h5A;
        bus_start();
        bus_wbyte({4'b0100, strap, 1'b0}, a);
        for (int i = 7; i >= 0; i--) begin
            bus_bit(d[i], s);
            if (i == 4) begin
                scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q);
            end
        end
        bus_bit(1'b1, s);
        bus_stop();
        tick(4);
        check("R9 data ack despite spike", {7'd0, ~s}, 8'h01);
        check("R9 ctrl unaffected by spike", ctrl, 8'h5A);
    endtask

    task automatic t_restart();
        logic a, ad, s;
        logic [7:0] ab = {4'b0100, strap, 1'b0};
        bus_start();
        for (int i = 7; i >= 5; i--) bus_bit(ab[i], s);
        bus_start();
        bus_wbyte(ab, a);
        bus_wbyte(8'hC6, ad);
        bus_stop();
        tick(4);
        check("R10 address acked after restart", {7'd0, a}, 8'h01);
        check("R10 ctrl after restart", ctrl, 8'hC6);
    endtask

    task automatic t_race();
        logic a;
        logic [7:0] st;
        bus_start();
        bus_wbyte({4'b0100, strap, 1'b1}, a);
        overload = 1'b1; tick(1); overload = 1'b0;
        bus_rbyte(1'b1, st);
        bus_stop();
        tick(4);
        check("R11 snapshot taken before event", st, 8'h04);
        check("R11 irq still low", {7'd0, irq_n}, 8'h00);
        read_status(st);
        check("R11 event kept", st, 8'h14);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_write();
        t_wrong_addr();
        t_sticky();
        t_answer_bits();
        t_supply();
        t_warm();
        t_glitch();
        t_restart();
        t_race();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule